// File: doc/BRIEF.md
# SAD Template Matching Engine

This engine finds where a small pixel template fits best inside a larger search window. A host writes the template and the search window pixel by pixel into two local buffers and then pulses a start input. The engine places the template at every offset where it lies fully inside the window. At each offset it adds up the absolute pixel differences, working through one template column per clock, so every offset costs as many cycles as the template has columns. One pass keeps the lowest sum and the position where it occurred.

Along with the winning position, the engine returns the 3x3 block of sums centred on it. The host can use these nine values for sub-pixel refinement. Offsets that fall outside the search grid report the largest value the accumulator can hold. The grid sums are kept in a single line buffer plus one diagonal register. The neighbours that are not yet known when a new minimum appears are filled in as the scan reaches them.

With the default parameters, the template is 18 rows by 22 columns and a 40-pixel border surrounds it. The window is therefore 98 by 102 pixels and the grid has 81 by 81 offsets.

Top module: `sad_match_engine`

## Requirements
- R1: After reset, done and tpl_fresh are 0, best_idx is 0, and every neighbourhood slot from 0 to 8 reads all ones, which is 2^ACC_W-1.
- R2: For grid offset (r,c), with r and c running from 0 to 2*BORDER, the sum is the total over template pixels (i,j) of |roi[r+i][c+j]-tpl[i][j]|. When done is 1, best_idx equals r*(2*BORDER+1)+c of the smallest sum.
- R3: When several offsets share the smallest sum, the one that comes first in raster order wins: rows top to bottom, and left to right within a row.
- R4: nb_sel = 3*(dr+1)+(dc+1) returns the sum at offset (r+dr, c+dc) around the winner (r,c), with dr and dc each in {-1,0,+1}. A slot outside the grid reads 2^ACC_W-1. nb_sel values from 9 to 15 read 0. Slot 4 holds the winning sum, and no slot is below it.
- R5: done goes to 1 exactly TPL_COLS*(2*BORDER+1)^2 clock edges after the edge that accepts start. It stays at 1 until the next start and reads 0 on the cycle after that start is accepted.
- R6: tpl_fresh goes to 1 on the cycle after a template write is accepted. It clears on the cycle after a start is accepted.
- R7: While a search runs, template writes, window writes and start pulses have no effect. The result matches the stored data and tpl_fresh stays 0.
- R8: An all-zero template is a valid input. Each sum then equals the total of the window pixels under the template.
- R9: Pixels are 8-bit unsigned. The accumulator has ACC_W = ceil(log2(255*TPL_ROWS*TPL_COLS+1)) bits and never wraps, even when every difference is 255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| tpl_we | input | 1 | Template pixel write strobe |
| tpl_row | input | TR_W | Template row of the write |
| tpl_col | input | TC_W | Template column of the write |
| tpl_pix | input | 8 | Template pixel value |
| roi_we | input | 1 | Search-window pixel write strobe |
| roi_row | input | RR_W | Search-window row of the write |
| roi_col | input | RC_W | Search-window column of the write |
| roi_pix | input | 8 | Search-window pixel value |
| start | input | 1 | Begin a search (ignored while one runs) |
| done | output | 1 | Result valid; held until the next start |
| tpl_fresh | output | 1 | New template data arrived since the last start |
| best_idx | output | IDX_W | Raster index of the winning offset |
| nb_sel | input | 4 | Neighbourhood slot select |
| nb_val | output | ACC_W | Selected neighbourhood sum |

## Verification
Several properties are checked on every cycle:
- done only rises right after the final offset has been evaluated.
- done holds until a start arrives and drops right after one.
- An accepted template write raises tpl_fresh.
- Whenever done is high, the centre slot is never larger than any of the nine neighbourhood slots.

The bench's scenarios cover what those properties cannot show:
- the exact cycle count of a search;
- the winning index and each neighbourhood value against sums computed independently;
- the earliest-offset tie rule;
- sums at the edges of the grid;
- blank templates and saturated windows;
- writes and start pulses that arrive mid-search and are ignored.

// File: rtl/sad_match_pkg.sv
package sad_match_pkg;

    localparam int PIX_W = 8;

    typedef logic [PIX_W-1:0] pixel_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } scan_state_t;

    function automatic int idx_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    function automatic pixel_t absdiff(input pixel_t a, input pixel_t b);
        return (a > b) ? (a - b) : (b - a);
    endfunction

endpackage

// File: rtl/sad_pixel_store.sv
module sad_pixel_store
    import sad_match_pkg::*;
#(
    parameter int ROWS = 4,
    parameter int COLS = 4,
    parameter int NRD  = 2,
    localparam int RW  = idx_w(ROWS),
    localparam int CW  = idx_w(COLS)
) (
    input  logic                        clk,
    input  logic                        we,
    input  logic [RW-1:0]               wr_row,
    input  logic [CW-1:0]               wr_col,
    input  pixel_t                      wr_pix,
    input  logic [RW-1:0]               rd_row,
    input  logic [CW-1:0]               rd_col,
    output logic [NRD-1:0][PIX_W-1:0]   rd_pix
);
    // one packed word per row keeps the element count at ROWS
    logic [COLS-1:0][PIX_W-1:0] mem_q [ROWS];

    logic in_range;
    assign in_range = ({1'b0, wr_row} < (RW+1)'(ROWS)) &&
                      ({1'b0, wr_col} < (CW+1)'(COLS));

    always_ff @(posedge clk) begin
        if (we && in_range)
            mem_q[wr_row][wr_col] <= wr_pix;
    end

    for (genvar i = 0; i < NRD; i++) begin : g_tap
        assign rd_pix[i] = mem_q[rd_row + RW'(i)][rd_col];
    end
endmodule

// File: rtl/sad_column_unit.sv
module sad_column_unit
    import sad_match_pkg::*;
#(
    parameter int NPIX  = 2,
    parameter int ACC_W = 12
) (
    input  logic [NPIX-1:0][PIX_W-1:0] a_pix,
    input  logic [NPIX-1:0][PIX_W-1:0] b_pix,
    output logic [ACC_W-1:0]           col_sum
);
    always_comb begin
        col_sum = '0;
        for (int i = 0; i < NPIX; i++)
            col_sum = col_sum + ACC_W'(absdiff(a_pix[i], b_pix[i]));
    end
endmodule

// File: rtl/sad_best_tracker.sv
module sad_best_tracker
    import sad_match_pkg::*;
#(
    parameter int GRID_ROWS = 5,
    parameter int GRID_COLS = 5,
    parameter int ACC_W     = 12,
    localparam int GR_W     = idx_w(GRID_ROWS),
    localparam int GC_W     = idx_w(GRID_COLS),
    localparam int IDX_W    = idx_w(GRID_ROWS * GRID_COLS)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       clear,
    input  logic                       eval,
    input  logic [ACC_W-1:0]           sad,
    input  logic [GR_W-1:0]            row,
    input  logic [GC_W-1:0]            col,
    output logic [IDX_W-1:0]           best_idx,
    output logic [8:0][ACC_W-1:0]      nb
);
    localparam logic [ACC_W-1:0] SAT = '1;

    logic [ACC_W-1:0] line_q [GRID_COLS];
    logic [ACC_W-1:0] diag_q;
    logic [8:0][ACC_W-1:0] nb_q;
    logic [GR_W-1:0] best_r_q;
    logic [GC_W-1:0] best_c_q;
    logic have_q;

    int r_i, c_i, br, bc;
    logic [ACC_W-1:0] up_v, ur_v, ul_v, lf_v;
    logic take;

    always_comb begin
        r_i  = int'(row);
        c_i  = int'(col);
        br   = int'(best_r_q);
        bc   = int'(best_c_q);
        up_v = (r_i > 0) ? line_q[col] : SAT;
        ur_v = (r_i > 0 && c_i < GRID_COLS-1) ? line_q[GC_W'(c_i+1)] : SAT;
        ul_v = (r_i > 0 && c_i > 0) ? diag_q : SAT;
        lf_v = (c_i > 0) ? line_q[GC_W'(c_i-1)] : SAT;
        take = !have_q || (sad < nb_q[4]);
        best_idx = IDX_W'(br * GRID_COLS + bc);
    end

    // line buffer: newest sum per column, plus the one it replaced
    always_ff @(posedge clk) begin
        if (eval) begin
            line_q[col] <= sad;
            diag_q      <= line_q[col];
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            have_q   <= 1'b0;
            best_r_q <= '0;
            best_c_q <= '0;
            nb_q     <= {9{SAT}};
        end else if (eval) begin
            if (take) begin
                have_q   <= 1'b1;
                best_r_q <= row;
                best_c_q <= col;
                nb_q[0]  <= ul_v;
                nb_q[1]  <= up_v;
                nb_q[2]  <= ur_v;
                nb_q[3]  <= lf_v;
                nb_q[4]  <= sad;
                nb_q[5]  <= SAT;
                nb_q[6]  <= SAT;
                nb_q[7]  <= SAT;
                nb_q[8]  <= SAT;
            end else begin
                // later neighbours arrive in raster order
                if (r_i == br && c_i == bc + 1) nb_q[5] <= sad;
                if (r_i == br + 1) begin
                    if (c_i == bc - 1) nb_q[6] <= sad;
                    if (c_i == bc)     nb_q[7] <= sad;
                    if (c_i == bc + 1) nb_q[8] <= sad;
                end
            end
        end
    end

    assign nb = nb_q;
endmodule

// File: rtl/sad_match_engine.sv
module sad_match_engine
    import sad_match_pkg::*;
#(
    parameter int TPL_ROWS  = 18,
    parameter int TPL_COLS  = 22,
    parameter int BORDER    = 40,
    localparam int ROI_ROWS  = TPL_ROWS + 2*BORDER,
    localparam int ROI_COLS  = TPL_COLS + 2*BORDER,
    localparam int GRID_ROWS = 2*BORDER + 1,
    localparam int GRID_COLS = 2*BORDER + 1,
    localparam int NPOS      = GRID_ROWS * GRID_COLS,
    localparam int ACC_W     = $clog2(TPL_ROWS*TPL_COLS*255 + 1),
    localparam int IDX_W     = idx_w(NPOS),
    localparam int TR_W      = idx_w(TPL_ROWS),
    localparam int TC_W      = idx_w(TPL_COLS),
    localparam int RR_W      = idx_w(ROI_ROWS),
    localparam int RC_W      = idx_w(ROI_COLS),
    localparam int GR_W      = idx_w(GRID_ROWS),
    localparam int GC_W      = idx_w(GRID_COLS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tpl_we,
    input  logic [TR_W-1:0]   tpl_row,
    input  logic [TC_W-1:0]   tpl_col,
    input  logic [7:0]        tpl_pix,
    input  logic              roi_we,
    input  logic [RR_W-1:0]   roi_row,
    input  logic [RC_W-1:0]   roi_col,
    input  logic [7:0]        roi_pix,
    input  logic              start,
    output logic              done,
    output logic              tpl_fresh,
    output logic [IDX_W-1:0]  best_idx,
    input  logic [3:0]        nb_sel,
    output logic [ACC_W-1:0]  nb_val
);
    scan_state_t state_q;
    logic [TC_W-1:0]  k_q;
    logic [GR_W-1:0]  row_q;
    logic [GC_W-1:0]  col_q;
    logic [ACC_W-1:0] acc_q;
    logic             fresh_q;

    logic running, start_acc, last_k, eval_w;
    logic [ACC_W-1:0] col_sum, sad_now;
    logic [TPL_ROWS-1:0][PIX_W-1:0] tpl_taps, roi_taps;
    logic [8:0][ACC_W-1:0] nb_w;

    assign running   = (state_q == ST_RUN);
    assign start_acc = start && !running;
    assign last_k    = (k_q == TC_W'(TPL_COLS-1));
    assign eval_w    = running && last_k;
    assign sad_now   = acc_q + col_sum;

    sad_pixel_store #(.ROWS(TPL_ROWS), .COLS(TPL_COLS), .NRD(TPL_ROWS)) u_tpl (
        .clk(clk), .we(tpl_we && !running), .wr_row(tpl_row), .wr_col(tpl_col),
        .wr_pix(tpl_pix), .rd_row('0), .rd_col(k_q), .rd_pix(tpl_taps)
    );

    sad_pixel_store #(.ROWS(ROI_ROWS), .COLS(ROI_COLS), .NRD(TPL_ROWS)) u_roi (
        .clk(clk), .we(roi_we && !running), .wr_row(roi_row), .wr_col(roi_col),
        .wr_pix(roi_pix), .rd_row(RR_W'(row_q)),
        .rd_col(RC_W'(col_q) + RC_W'(k_q)), .rd_pix(roi_taps)
    );

    sad_column_unit #(.NPIX(TPL_ROWS), .ACC_W(ACC_W)) u_col (
        .a_pix(roi_taps), .b_pix(tpl_taps), .col_sum(col_sum)
    );

    sad_best_tracker #(.GRID_ROWS(GRID_ROWS), .GRID_COLS(GRID_COLS), .ACC_W(ACC_W)) u_best (
        .clk(clk), .rst(rst), .clear(start_acc), .eval(eval_w), .sad(sad_now),
        .row(row_q), .col(col_q), .best_idx(best_idx), .nb(nb_w)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            k_q     <= '0;
            row_q   <= '0;
            col_q   <= '0;
            acc_q   <= '0;
        end else if (start_acc) begin
            state_q <= ST_RUN;
            k_q     <= '0;
            row_q   <= '0;
            col_q   <= '0;
            acc_q   <= '0;
        end else if (running) begin
            if (last_k) begin
                k_q   <= '0;
                acc_q <= '0;
                if (col_q == GC_W'(GRID_COLS-1)) begin
                    col_q <= '0;
                    if (row_q == GR_W'(GRID_ROWS-1)) state_q <= ST_DONE;
                    else                             row_q   <= row_q + 1'b1;
                end else begin
                    col_q <= col_q + 1'b1;
                end
            end else begin
                k_q   <= k_q + 1'b1;
                acc_q <= sad_now;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                      fresh_q <= 1'b0;
        else if (tpl_we && !running)  fresh_q <= 1'b1;
        else if (start_acc)           fresh_q <= 1'b0;
    end

    assign done      = (state_q == ST_DONE);
    assign tpl_fresh = fresh_q;
    assign nb_val    = (nb_sel < 4'd9) ? nb_w[nb_sel] : '0;
endmodule

// File: rtl/sad_engine_checks.sv
module sad_engine_checks #(
    parameter int ACC_W = 12
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  start,
    input logic                  done,
    input logic                  eval,
    input logic                  running,
    input logic                  tpl_we,
    input logic                  tpl_fresh,
    input logic [8:0][ACC_W-1:0] nb
);
    function automatic bit centre_lowest(input logic [8:0][ACC_W-1:0] v);
        for (int s = 0; s < 9; s++)
            if (v[s] < v[4]) return 1'b0;
        return 1'b1;
    endfunction

    a_r5_rise_after_last_eval: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(eval));

    a_r5_done_holds: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> done);

    a_r5_start_clears_done: assert property (@(posedge clk) disable iff (rst)
        (done && start) |=> !done);

    a_r4_centre_not_above_neighbours: assert property (@(posedge clk) disable iff (rst)
        done |-> centre_lowest(nb));

    a_r6_write_sets_fresh: assert property (@(posedge clk) disable iff (rst)
        (tpl_we && !running) |=> tpl_fresh);
endmodule

bind sad_match_engine sad_engine_checks #(.ACC_W(ACC_W)) u_checks (
    .clk(clk), .rst(rst), .start(start), .done(done), .eval(eval_w),
    .running(running), .tpl_we(tpl_we), .tpl_fresh(tpl_fresh), .nb(nb_w)
);

// File: tb/sad_match_engine_test.sv
module sad_match_engine_test;
    localparam int TR  = 2;
    localparam int TC  = 3;
    localparam int BD  = 2;
    localparam int RR  = TR + 2*BD;
    localparam int RC  = TC + 2*BD;
    localparam int GR  = 2*BD + 1;
    localparam int GC  = 2*BD + 1;
    localparam int AW  = $clog2(TR*TC*255 + 1);
    localparam int SAT = (1 << AW) - 1;
    localparam int NCYC = TC * GR * GC;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tpl_we = 1'b0, roi_we = 1'b0, start = 1'b0;
    logic [0:0] tpl_row = '0;
    logic [1:0] tpl_col = '0;
    logic [2:0] roi_row = '0, roi_col = '0;
    logic [7:0] tpl_pix = '0, roi_pix = '0;
    logic [3:0] nb_sel = '0;
    logic done, tpl_fresh;
    logic [4:0] best_idx;
    logic [AW-1:0] nb_val;

    int checks = 0;
    int failures = 0;
    int tpl_m [TR][TC];
    int roi_m [RR][RC];
    int sad_m [GR][GC];
    int exp_idx;
    int exp_nb [9];
    int seed = 12345;

    always #2 clk = ~clk;

    sad_match_engine #(.TPL_ROWS(TR), .TPL_COLS(TC), .BORDER(BD)) uut (
        .clk(clk), .rst(rst), .tpl_we(tpl_we), .tpl_row(tpl_row), .tpl_col(tpl_col),
        .tpl_pix(tpl_pix), .roi_we(roi_we), .roi_row(roi_row), .roi_col(roi_col),
        .roi_pix(roi_pix), .start(start), .done(done), .tpl_fresh(tpl_fresh),
        .best_idx(best_idx), .nb_sel(nb_sel), .nb_val(nb_val)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int next_rand();
        seed = (seed * 1103515245 + 12345) & 32'h7fffffff;
        return (seed >> 8) & 255;
    endfunction

    task automatic compute_expected();
        int best;
        best = -1;
        for (int r = 0; r < GR; r++)
            for (int c = 0; c < GC; c++) begin
                int s;
                s = 0;
                for (int i = 0; i < TR; i++)
                    for (int j = 0; j < TC; j++) begin
                        int d;
                        d = roi_m[r+i][c+j] - tpl_m[i][j];
                        s += (d < 0) ? -d : d;
                    end
                sad_m[r][c] = s;
                if (best < 0 || s < best) begin
                    best = s;
                    exp_idx = r*GC + c;
                end
            end
        for (int s = 0; s < 9; s++) begin
            int rr, cc;
            rr = exp_idx / GC + s / 3 - 1;
            cc = exp_idx % GC + s % 3 - 1;
            exp_nb[s] = (rr >= 0 && rr < GR && cc >= 0 && cc < GC) ? sad_m[rr][cc] : SAT;
        end
    endtask

    task automatic load_all();
        for (int i = 0; i < TR; i++)
            for (int j = 0; j < TC; j++) begin
                @(negedge clk);
                tpl_we = 1'b1; tpl_row = 1'(i); tpl_col = 2'(j); tpl_pix = 8'(tpl_m[i][j]);
            end
        for (int i = 0; i < RR; i++)
            for (int j = 0; j < RC; j++) begin
                @(negedge clk);
                tpl_we = 1'b0;
                roi_we = 1'b1; roi_row = 3'(i); roi_col = 3'(j); roi_pix = 8'(roi_m[i][j]);
            end
        @(negedge clk);
        roi_we = 1'b0;
    endtask

    task automatic plant(input int r0, input int c0);
        for (int i = 0; i < TR; i++)
            for (int j = 0; j < TC; j++)
                roi_m[r0+i][c0+j] = tpl_m[i][j];
    endtask

    task automatic search(input string req, input bit poke);
        int cnt;
        compute_expected();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(done == 1'b0, "R5", "done cleared after start", int'(done), 0);
        check(tpl_fresh == 1'b0, "R6", "fresh cleared by start", int'(tpl_fresh), 0);
        cnt = 1;
        while (!done && cnt <= 4*NCYC) begin
            @(negedge clk);
            if (poke && cnt == 5) begin
                start = 1'b1;
                tpl_we = 1'b1; tpl_row = '0; tpl_col = '0; tpl_pix = 8'd255;
                roi_we = 1'b1; roi_row = 3'd1; roi_col = 3'd1; roi_pix = 8'd0;
            end else begin
                start = 1'b0; tpl_we = 1'b0; roi_we = 1'b0;
            end
            if (!done) cnt++;
        end
        start = 1'b0; tpl_we = 1'b0; roi_we = 1'b0;
        check(cnt == NCYC, "R5", "cycles from start to done", cnt, NCYC);
        if (poke)
            check(tpl_fresh == 1'b0, "R7", "fresh after mid-search write", int'(tpl_fresh), 0);
        check(int'(best_idx) == exp_idx, req, "best index", int'(best_idx), exp_idx);
        for (int s = 0; s < 9; s++) begin
            nb_sel = 4'(s);
            #1;
            check(int'(nb_val) == exp_nb[s], (poke ? "R7" : "R4"), $sformatf("slot %0d", s),
                  int'(nb_val), exp_nb[s]);
        end
        nb_sel = 4'd9;
        #1;
        check(nb_val == '0, "R4", "slot 9 reads zero", int'(nb_val), 0);
        nb_sel = 4'd15;
        #1;
        check(nb_val == '0, "R4", "slot 15 reads zero", int'(nb_val), 0);
        repeat (3) @(negedge clk);
        check(done == 1'b1, "R5", "done held", int'(done), 1);
    endtask

    initial begin
        #400000;
        failures++;
        checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(done == 1'b0, "R1", "done", int'(done), 0);
        check(tpl_fresh == 1'b0, "R1", "tpl_fresh", int'(tpl_fresh), 0);
        check(best_idx == '0, "R1", "best_idx", int'(best_idx), 0);
        for (int s = 0; s < 9; s++) begin
            nb_sel = 4'(s);
            #1;
            check(int'(nb_val) == SAT, "R1", $sformatf("slot %0d", s), int'(nb_val), SAT);
        end

        // R8 blank template over a random window
        for (int i = 0; i < TR; i++) for (int j = 0; j < TC; j++) tpl_m[i][j] = 0;
        for (int i = 0; i < RR; i++) for (int j = 0; j < RC; j++) roi_m[i][j] = next_rand();
        load_all();
        check(tpl_fresh == 1'b1, "R6", "fresh after template load", int'(tpl_fresh), 1);
        search("R8", 1'b0);

        // R2 random data, two exact copies: R3 earliest copy wins
        for (int i = 0; i < TR; i++) for (int j = 0; j < TC; j++) tpl_m[i][j] = next_rand();
        for (int i = 0; i < RR; i++) for (int j = 0; j < RC; j++) roi_m[i][j] = next_rand();
        plant(3, 3);
        plant(1, 0);
        load_all();
        search("R3", 1'b0);

        // R4 winner at the last grid corner
        for (int i = 0; i < RR; i++) for (int j = 0; j < RC; j++) roi_m[i][j] = next_rand();
        plant(GR-1, GC-1);
        load_all();
        search("R4", 1'b0);

        // R2 purely random data, no planted copy
        for (int pass = 0; pass < 2; pass++) begin
            for (int i = 0; i < TR; i++) for (int j = 0; j < TC; j++) tpl_m[i][j] = next_rand();
            for (int i = 0; i < RR; i++) for (int j = 0; j < RC; j++) roi_m[i][j] = next_rand();
            load_all();
            search("R2", 1'b0);
        end

        // R9 saturated differences, all tied: R3 index 0
        for (int i = 0; i < TR; i++) for (int j = 0; j < TC; j++) tpl_m[i][j] = 0;
        for (int i = 0; i < RR; i++) for (int j = 0; j < RC; j++) roi_m[i][j] = 255;
        load_all();
        search("R9", 1'b0);

        // R7 writes and start during a search are ignored
        search("R7", 1'b1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule